// File: doc/BRIEF.md
# Disk byte-boundary CPU handshake

This block couples an 8-bit CPU port to the byte-wide side of a serial disk data path. A half-bit-cell strobe comes in from outside, and the block counts it to find the byte boundaries. When the CPU touches the data port, the block holds a wait line active until the next boundary. At that boundary it completes the exchange between the CPU and the shift registers, then lets the bus cycle finish. A byte time therefore paces every CPU data access.

When writing, the CPU byte loads the data shift register. At the same moment the clock holding register is copied into the clock shift register. When reading, the CPU receives the byte assembled at the boundary, and the clock pattern of that byte lands in the clock holding register.

Three flags are reported in two status bytes:
- An overrun flag, set when a boundary passes without a CPU data access.
- A CRC error flag, reloaded at each boundary from a test of the external CRC word.
- A timeout flag, driven by a long one-shot that software starts. When margin checking is enabled, this one-shot can also free a stalled CPU.

The half-bit rate is 1 MHz in high-density operation and 500 kHz in low-density operation. That rate is set by whoever drives the strobe. The serializer, the encoder and the data separator sit outside this block.

Top module: `disk_byte_handshake`

## Requirements
- R1: A CPU access to port 0 (data) drives `cpu_wait` high in the same cycle as the access. `cpu_wait` stays high until a byte boundary (or a timeout release, R7) is registered, and it is low in the following cycle.
- R2: At a boundary that completes a data-port write, the data shift register takes `cpu_wdata` and the clock shift register takes the clock holding register. This holds in either direction mode.
- R3: With `rd_mode` high, every boundary loads the data and clock shift registers from `disk_data_in` and `disk_clk_in`. A data-port read completed at that boundary returns `disk_data_in`, and it copies `disk_clk_in` into the clock holding register.
- R4: A boundary with no data-port access pending sets the overrun flag. Writing port 2 with bit 1 set clears the flag, but a boundary in the same cycle wins. Boundaries that each complete an access leave the flag clear.
- R5: While `xfer_en` is high, a byte boundary occurs on every 16th `half_bit_stb`. The count restarts whenever `xfer_en` is low.
- R6: At every boundary, the CRC error flag takes 1 if `crc_in` is non-zero and 0 otherwise. Between boundaries it holds.
- R7: Writing port 2 with bit 0 set clears the timeout flag and starts a one-shot of `TIMEOUT_CYCLES` clocks, which is 450 ms at 125 MHz by default. Expiry sets the flag. If `margin_en` is high, expiry also releases a stalled data access without an exchange. If `margin_en` is low, a stalled access waits for a boundary.
- R8: Reading port 2 gives CRC error in bit 5 and overrun in bit 6. Reading port 3 gives timeout in bit 6 and `amark_in` in bit 7. All other bits read 0. After reset, the timeout flag is 1 and the other flags, the shift registers and the holding registers are 0.
- R9: Port 1 reads and writes the clock holding register. Accesses to ports 1, 2 and 3 never assert `cpu_wait`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_bit_stb | input | 1 | One-cycle pulse per half bit cell |
| xfer_en | input | 1 | Enables byte-boundary generation |
| rd_mode | input | 1 | 1: shift registers load from the disk side at boundaries |
| margin_en | input | 1 | Lets timeout expiry release a stalled access |
| amark_in | input | 1 | Address-mark-detected indication, shown in status byte 2 |
| cpu_sel | input | 1 | CPU access strobe, held until `cpu_wait` is low |
| cpu_we | input | 1 | 1: write, 0: read |
| cpu_addr | input | 2 | Port: 0 data, 1 clock holding, 2 status/control, 3 status 2 |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data |
| cpu_wait | output | 1 | Stall request to the CPU |
| disk_data_in | input | 8 | Data byte assembled by the deserializer |
| disk_clk_in | input | 8 | Clock-bit byte assembled by the deserializer |
| crc_in | input | 16 | Current CRC register value |
| dsr_out | output | 8 | Data shift register toward the serializer |
| csr_out | output | 8 | Clock shift register toward the serializer |

## Verification
On every cycle, the assertions check the following:
- the wait line drops only after a registered boundary or release;
- an idle boundary always raises overrun;
- the CRC flag follows the CRC word sampled at each boundary;
- the write and read exchanges move the right registers;
- the one-shot start and expiry change the timeout flag.

Only the bench scenarios can show how long a stall lasts in byte terms, the values that come back through the status ports, and that an idle boundary in read mode loads the shift registers. They also show that a stalled access without margin checking outlives the timeout and ends only at a boundary.

// File: rtl/dbh_pkg.sv
// Package: port map and bit positions shared by the handshake block and
// its bench. Assumes a 2-bit CPU port address.
package dbh_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] PORT_DATA    = 2'd0;
    localparam logic [ADDR_W-1:0] PORT_CLKHOLD = 2'd1;
    localparam logic [ADDR_W-1:0] PORT_STAT    = 2'd2;
    localparam logic [ADDR_W-1:0] PORT_STAT2   = 2'd3;

    // Control write to PORT_STAT
    localparam int CTL_TMO_START = 0;
    localparam int CTL_OVR_CLR   = 1;
    // Status byte (PORT_STAT read)
    localparam int ST_CRC = 5;
    localparam int ST_OVR = 6;
    // Second status byte (PORT_STAT2 read)
    localparam int ST2_TMO = 6;
    localparam int ST2_AM  = 7;
endpackage

// File: rtl/dbh_boundary_gen.sv
// Byte-boundary generator: counts half-bit strobes and flags the strobe
// that ends each byte. Assumes half_bit_stb is a single-cycle pulse;
// the count is cleared while en is low.
module dbh_boundary_gen #(
    parameter int CELLS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic half_stb,
    output logic byte_stb
);
    localparam int CW = (CELLS > 1) ? $clog2(CELLS) : 1;
    localparam logic [CW-1:0] LAST = CW'(CELLS - 1);

    logic [CW-1:0] cnt;

    assign byte_stb = en && half_stb && (cnt == LAST);

    // Half-bit cell counter, wrapping at each byte
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt <= '0;
        end else if (half_stb) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // A boundary resets the count, so a boundary never follows a boundary
    // unless a whole byte of strobes fits in one cycle (impossible here).
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> !byte_stb) else $error("boundary twice in a row"); // R5
endmodule

// File: rtl/dbh_oneshot.sv
// Timeout one-shot: start loads a down-counter and clears the flag;
// reaching the end sets the flag and pulses expire for one cycle.
// Assumes CYCLES >= 2. Flag is set out of reset.
module dbh_oneshot #(
    parameter int CYCLES = 56_250_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic flag,
    output logic expire
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOADV = CW'(CYCLES);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] cnt;

    assign expire = (cnt == ONE) && !start;

    // Down-counter and timeout flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            flag <= 1'b1;
        end else if (start) begin
            cnt  <= LOADV;
            flag <= 1'b0;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
            if (cnt == ONE) flag <= 1'b1;
        end
    end

    AST_TMO_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !flag) else $error("start did not clear timeout"); // R7
    AST_TMO_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag) else $error("expiry did not set timeout"); // R7
endmodule

// File: rtl/dbh_xfer.sv
// Data exchange and stall control. A data-port access raises wait at once
// and is completed at the next byte boundary (or a timeout release);
// the grant is held until the CPU drops the access. Also keeps the
// overrun and CRC error flags. Assumes the CPU holds sel/we/addr/wdata
// stable while wait is high.
module dbh_xfer
    import dbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_stb,
    input  logic              tmo_release,
    input  logic              rd_mode,
    input  logic              cpu_sel,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              ovr_clr,
    input  logic [7:0]        disk_data,
    input  logic [7:0]        disk_clk,
    input  logic [15:0]       crc_reg,
    output logic              cpu_wait,
    output logic [7:0]        rd_hold,
    output logic [7:0]        chold,
    output logic [7:0]        dsr,
    output logic [7:0]        csr,
    output logic              ovr_flag,
    output logic              crc_err
);
    logic is_data;
    logic acc_now;
    logic grant;

    assign is_data  = cpu_sel && (cpu_addr == PORT_DATA);
    assign acc_now  = is_data && !grant;
    assign cpu_wait = acc_now;

    // Grant: set when the pending access is completed, dropped with the access
    always_ff @(posedge clk) begin
        if (!rst_n || !is_data) begin
            grant <= 1'b0;
        end else if (acc_now && (byte_stb || tmo_release)) begin
            grant <= 1'b1;
        end
    end

    // Shift registers: disk-side load in read mode, CPU write overrides
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dsr <= '0;
            csr <= '0;
        end else if (byte_stb) begin
            if (acc_now && cpu_we) begin
                dsr <= cpu_wdata;
                csr <= chold;
            end else if (rd_mode) begin
                dsr <= disk_data;
                csr <= disk_clk;
            end
        end
    end

    // Read-return byte captured when a read completes at a boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_hold <= '0;
        end else if (byte_stb && acc_now && !cpu_we) begin
            rd_hold <= rd_mode ? disk_data : dsr;
        end
    end

    // Clock holding register: CPU port write or copy on read completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chold <= '0;
        end else if (cpu_sel && cpu_we && (cpu_addr == PORT_CLKHOLD)) begin
            chold <= cpu_wdata;
        end else if (byte_stb && acc_now && !cpu_we) begin
            chold <= rd_mode ? disk_clk : csr;
        end
    end

    // Overrun flag: set by an idle boundary, which wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_flag <= 1'b0;
        end else if (byte_stb && !acc_now) begin
            ovr_flag <= 1'b1;
        end else if (ovr_clr) begin
            ovr_flag <= 1'b0;
        end
    end

    // CRC error flag sampled at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            crc_err <= 1'b0;
        end else if (byte_stb) begin
            crc_err <= (crc_reg != 16'h0000);
        end
    end

    AST_WAIT_RELEASE_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_wait) && !cpu_wait && cpu_sel && $past(cpu_sel)
         && (cpu_addr == PORT_DATA) && ($past(cpu_addr) == PORT_DATA))
        |-> $past(byte_stb || tmo_release)) else $error("wait dropped early"); // R1
    AST_WR_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && cpu_wait && cpu_we)
        |=> (dsr == $past(cpu_wdata)) && (csr == $past(chold))) else $error("write exchange"); // R2
    AST_RD_EXCHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && cpu_wait && !cpu_we && rd_mode)
        |=> (rd_hold == $past(disk_data)) && (chold == $past(disk_clk))) else $error("read exchange"); // R3
    AST_OVR_ON_IDLE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb && !cpu_wait) |=> ovr_flag) else $error("overrun missed"); // R4
    AST_CRC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_stb |=> (crc_err == ($past(crc_reg) != 16'h0000))) else $error("crc flag"); // R6
endmodule

// File: rtl/disk_byte_handshake.sv
// Top: byte-boundary CPU handshake for a serial disk data path. Ties the
// boundary generator, the timeout one-shot and the exchange logic
// together and decodes the CPU port. Assumes single-cycle strobes for
// accesses to ports 1..3.
module disk_byte_handshake
    import dbh_pkg::*;
#(
    parameter int CELLS_PER_BYTE = 16,
    parameter int TIMEOUT_CYCLES = 56_250_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        half_bit_stb,
    input  logic        xfer_en,
    input  logic        rd_mode,
    input  logic        margin_en,
    input  logic        amark_in,
    input  logic        cpu_sel,
    input  logic        cpu_we,
    input  logic [1:0]  cpu_addr,
    input  logic [7:0]  cpu_wdata,
    output logic [7:0]  cpu_rdata,
    output logic        cpu_wait,
    input  logic [7:0]  disk_data_in,
    input  logic [7:0]  disk_clk_in,
    input  logic [15:0] crc_in,
    output logic [7:0]  dsr_out,
    output logic [7:0]  csr_out
);
    logic       byte_stb;
    logic       ctl_wr;
    logic       tmo_start;
    logic       ovr_clr;
    logic       tmo_flag;
    logic       tmo_expire;
    logic       ovr_flag;
    logic       crc_err;
    logic [7:0] rd_hold;
    logic [7:0] chold;

    assign ctl_wr    = cpu_sel && cpu_we && (cpu_addr == PORT_STAT);
    assign tmo_start = ctl_wr && cpu_wdata[CTL_TMO_START];
    assign ovr_clr   = ctl_wr && cpu_wdata[CTL_OVR_CLR];

    dbh_boundary_gen #(.CELLS(CELLS_PER_BYTE)) u_bnd (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (xfer_en),
        .half_stb (half_bit_stb),
        .byte_stb (byte_stb)
    );

    dbh_oneshot #(.CYCLES(TIMEOUT_CYCLES)) u_tmo (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (tmo_start),
        .flag   (tmo_flag),
        .expire (tmo_expire)
    );

    dbh_xfer u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb    (byte_stb),
        .tmo_release (tmo_expire && margin_en),
        .rd_mode     (rd_mode),
        .cpu_sel     (cpu_sel),
        .cpu_we      (cpu_we),
        .cpu_addr    (cpu_addr),
        .cpu_wdata   (cpu_wdata),
        .ovr_clr     (ovr_clr),
        .disk_data   (disk_data_in),
        .disk_clk    (disk_clk_in),
        .crc_reg     (crc_in),
        .cpu_wait    (cpu_wait),
        .rd_hold     (rd_hold),
        .chold       (chold),
        .dsr         (dsr_out),
        .csr         (csr_out),
        .ovr_flag    (ovr_flag),
        .crc_err     (crc_err)
    );

    // CPU read-data multiplexer
    always_comb begin
        cpu_rdata = '0;
        case (cpu_addr)
            PORT_DATA:    cpu_rdata = rd_hold;
            PORT_CLKHOLD: cpu_rdata = chold;
            PORT_STAT: begin
                cpu_rdata[ST_CRC] = crc_err;
                cpu_rdata[ST_OVR] = ovr_flag;
            end
            default: begin
                cpu_rdata[ST2_TMO] = tmo_flag;
                cpu_rdata[ST2_AM]  = amark_in;
            end
        endcase
    end

    AST_AUX_PORT_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_sel && (cpu_addr != PORT_DATA)) |-> !cpu_wait) else $error("aux port stalled"); // R9
endmodule

// File: tb/disk_byte_handshake_tb.sv
// Scoreboard bench: read tasks queue expected bytes, a monitor pops and
// compares them when a read completes; other checks go through chk().
module disk_byte_handshake_tb;
    import dbh_pkg::*;

    localparam int TMO    = 200;
    localparam int HB_DIV = 4;
    localparam int CELLS  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        half_bit_stb = 1'b0;
    logic        xfer_en = 1'b0;
    logic        rd_mode = 1'b0;
    logic        margin_en = 1'b0;
    logic        amark_in = 1'b0;
    logic        cpu_sel = 1'b0;
    logic        cpu_we = 1'b0;
    logic [1:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic [7:0]  disk_data_in = '0;
    logic [7:0]  disk_clk_in = '0;
    logic [15:0] crc_in = '0;
    logic [7:0]  dsr_out;
    logic [7:0]  csr_out;

    int nchk = 0;
    int nfail = 0;
    logic [7:0] qv[$];
    string      qt[$];
    event bnd_ev;

    disk_byte_handshake #(.CELLS_PER_BYTE(CELLS), .TIMEOUT_CYCLES(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .half_bit_stb(half_bit_stb), .xfer_en(xfer_en),
        .rd_mode(rd_mode), .margin_en(margin_en), .amark_in(amark_in),
        .cpu_sel(cpu_sel), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata), .cpu_wait(cpu_wait), .disk_data_in(disk_data_in),
        .disk_clk_in(disk_clk_in), .crc_in(crc_in), .dsr_out(dsr_out), .csr_out(csr_out)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Half-bit strobe source; counts its own strobes to know the boundaries
    initial begin
        int div = 0;
        int nstb = 0;
        forever begin
            @(posedge clk); #2;
            if (xfer_en) begin
                if (div == HB_DIV - 1) begin
                    div = 0;
                    half_bit_stb = 1'b1;
                    nstb++;
                    if (nstb % CELLS == 0) -> bnd_ev;
                end else begin
                    div++;
                    half_bit_stb = 1'b0;
                end
            end else begin
                div = 0;
                nstb = 0;
                half_bit_stb = 1'b0;
            end
        end
    end

    // Monitor: compare each completed read against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && cpu_sel && !cpu_we && !cpu_wait) begin
                if (qv.size() == 0) begin
                    nchk++; nfail++;
                    $display("FAIL unexpected read actual=%0h expected=none", cpu_rdata);
                end else begin
                    chk(qt.pop_front(), cpu_rdata, qv.pop_front());
                end
            end
        end
    end

    // One bus cycle; returns the number of stalled cycles and first-cycle wait
    task automatic bus_cycle(input logic [1:0] a, input logic we, input logic [7:0] d,
                             output int stalls, output logic fw);
        cpu_sel = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        stalls = 0;
        fw = 1'b0;
        forever begin
            @(negedge clk);
            if (stalls == 0) fw = cpu_wait;
            if (!cpu_wait) break;
            stalls++;
            @(posedge clk); #1;
        end
        @(posedge clk); #1;
        cpu_sel = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        int s; logic f;
        bus_cycle(a, 1'b1, d, s, f);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        int s; logic f;
        qv.push_back(exp); qt.push_back(tag);
        bus_cycle(a, 1'b0, 8'h00, s, f);
    endtask

    task automatic sync_after_bnd();
        @(bnd_ev);
        @(posedge clk); #1;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        int s; logic f;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;

        // R8: reset state
        chk("R8 reset wait", cpu_wait, 0);
        rd(PORT_STAT, 8'h00, "R8 reset status");
        rd(PORT_STAT2, 8'h40, "R8 reset status2 timeout set");
        chk("R8 reset dsr", dsr_out, 0);
        chk("R8 reset csr", csr_out, 0);

        // R9: clock holding register, no stall
        bus_cycle(PORT_CLKHOLD, 1'b1, 8'hA5, s, f);
        chk("R9 clkhold write stalls", s, 0);
        rd(PORT_CLKHOLD, 8'hA5, "R9 clkhold readback");

        // R1/R2/R5: data write stalls until the boundary
        xfer_en = 1'b1;
        sync_after_bnd();
        bus_cycle(PORT_DATA, 1'b1, 8'h3C, s, f);
        chk("R1 wait in access cycle", f, 1);
        chk("R5 stall within one byte", (s >= 56 && s <= 64), 1);
        chk("R2 dsr after write", dsr_out, 8'h3C);
        chk("R2 csr from clkhold", csr_out, 8'hA5);

        // R4: idle boundary sets overrun; clear works
        sync_after_bnd();
        rd(PORT_STAT, 8'h40, "R4 overrun set");
        wr(PORT_STAT, 8'h02);
        rd(PORT_STAT, 8'h00, "R4 overrun cleared");

        // R6: CRC flag tracks the CRC word at boundaries
        crc_in = 16'h1234;
        sync_after_bnd();
        wr(PORT_STAT, 8'h02);
        rd(PORT_STAT, 8'h20, "R6 crc nonzero");
        crc_in = 16'h0000;
        sync_after_bnd();
        wr(PORT_STAT, 8'h02);
        rd(PORT_STAT, 8'h00, "R6 crc zero");

        // R3: read mode exchange
        rd_mode = 1'b1; disk_data_in = 8'h96; disk_clk_in = 8'hC7;
        sync_after_bnd();
        wr(PORT_STAT, 8'h02);
        rd(PORT_DATA, 8'h96, "R3 data read returns disk byte");
        rd(PORT_CLKHOLD, 8'hC7, "R3 clock copied to holding");
        chk("R3 dsr loaded", dsr_out, 8'h96);
        chk("R3 csr loaded", csr_out, 8'hC7);
        rd(PORT_DATA, 8'h96, "R3 second data read");
        rd(PORT_STAT, 8'h00, "R4 no overrun with access each byte");

        // R3: idle boundary in read mode still loads shift registers
        disk_data_in = 8'h5A; disk_clk_in = 8'h0F;
        sync_after_bnd();
        chk("R3 idle load dsr", dsr_out, 8'h5A);
        chk("R3 idle load csr", csr_out, 8'h0F);
        disk_data_in = 8'h96; disk_clk_in = 8'hC7;

        // R7: timeout start and expiry
        wr(PORT_STAT, 8'h01);
        rd(PORT_STAT2, 8'h00, "R7 timeout cleared by start");
        repeat (TMO + 10) @(posedge clk);
        #1;
        rd(PORT_STAT2, 8'h40, "R7 timeout set on expiry");

        // R7: margin enabled -> expiry releases a stalled read
        xfer_en = 1'b0; margin_en = 1'b1;
        @(posedge clk); #1;
        wr(PORT_STAT, 8'h01);
        qv.push_back(8'h96); qt.push_back("R7 released read keeps last byte");
        bus_cycle(PORT_DATA, 1'b0, 8'h00, s, f);
        chk("R7 release by timeout", (s >= TMO - 10 && s <= TMO + 2), 1);

        // R7: margin disabled -> stall outlives timeout, ends at boundary
        margin_en = 1'b0;
        wr(PORT_STAT, 8'h01);
        fork
            bus_cycle(PORT_DATA, 1'b1, 8'h77, s, f);
            begin
                repeat (TMO + 100) @(posedge clk);
                #1 xfer_en = 1'b1;
            end
        join
        chk("R7 no release without margin", (s > TMO + 90), 1);
        chk("R2 write in read mode dsr", dsr_out, 8'h77);
        chk("R2 write in read mode csr", csr_out, 8'hC7);

        // R8: address mark in status byte 2
        amark_in = 1'b1;
        rd(PORT_STAT2, 8'hC0, "R8 address mark bit");

        repeat (4) @(posedge clk);
        chk("scoreboard drained", qv.size(), 0);
        finish_run();
    end
endmodule